// File: doc/BRIEF.md
# Programmable Table-Driven State Machine

This block is a finite state machine whose behaviour is set at run time and not fixed in logic. A state register holds the current state index. A writable lookup table is indexed by the current state joined with the present input vector. The selected entry supplies two things: the next state, which the state register loads on every clock edge, and the output vector, which reaches the outputs combinationally. An entry can therefore make the output depend on the current input, as in a Mealy machine, or only on the state, as in a Moore machine. One netlist can be loaded to act as any machine that fits the parameters.

Software uses a small register port to program the table. It first selects an entry index and a 32-bit slice of that entry, then writes a data word, and that write commits the slice. The same port issues a soft restart that returns the machine to state 0 and leaves the table unchanged, and it reads back the current state index. The state width, input width and output width are parameters. The default is 2 state bits, 1 input bit and 1 output bit, which gives four states and an 8-entry table.

Top module: `lut_fsm`

## Requirements
- R1: After hardware reset the state is 0 and every table entry is 0, so the outputs are 0 and the machine stays in state 0 for any input.
- R2: On each rising clock edge without a restart, the state register loads the next-state field of the entry at index {state, in_i}. The state forms the high bits of the index and the input forms the low bits.
- R3: out_o equals the output field of the entry at index {state, in_i}. It follows a change of in_i within the same cycle, with no clock edge needed.
- R4: An entry is {next_state, outputs}, with the outputs in bits [OUTPUT_W-1:0] and the next state directly above them. A write to register 2 stores data bits into slice k of the entry chosen by register 0, where k is the value of register 1 and slice k covers entry bits [32k+31:32k].
- R5: A data write whose slice select is not below ceil((STATE_W+OUTPUT_W)/32) changes no entry.
- R6: A write to register 3, whatever its data, sets the state to 0 at the next edge and leaves the table unchanged.
- R7: Reading register 4 returns the current state zero-extended. Reading registers 0 and 1 returns the stored index and the stored slice select.
- R8: A data write to the entry currently in use does not change out_o or the next state until the clock edge that commits it. The state loaded at that edge comes from the old entry.
- R9: Writes to registers 0 and 1 alone change neither the table, the state nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| in_i | input | INPUT_W | Machine input vector |
| out_o | output | OUTPUT_W | Machine output vector |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |

## Verification
The bench loads a four-state program and walks it with an input sequence chosen so that every state is reached both with input 0 and with input 1. This shows whether the table is indexed with the state bits on top, because a swapped index would send the machine down a different path. State 3 copies its input to the output, and this exposes a registered output in place of a combinational one. An input run that holds and then loops back through state 0 separates a correct next-state field from a shifted one. Directed cases rewrite the entry in use during its own cycle, issue an out-of-range slice write, and restart from a non-zero state; each of these makes a distinct fault visible at the outputs.

// File: rtl/lut_fsm_pkg.sv
package lut_fsm_pkg;
  typedef enum logic [2:0] {
    REG_IDX     = 3'd0,
    REG_SEL     = 3'd1,
    REG_DATA    = 3'd2,
    REG_RESTART = 3'd3,
    REG_STATE   = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/lut_fsm_regs.sv
module lut_fsm_regs
  import lut_fsm_pkg::*;
#(
  parameter int IDX_W   = 3,
  parameter int SEL_W   = 1,
  parameter int STATE_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [2:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  input  logic [STATE_W-1:0] state_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic [SEL_W-1:0]   sel_o,
  output logic               wr_en_o,
  output logic               restart_o
);
  logic [IDX_W-1:0] idx_q;
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      sel_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == REG_IDX) idx_q <= reg_wdata_i[IDX_W-1:0];
      if (reg_addr_i == REG_SEL) sel_q <= reg_wdata_i[SEL_W-1:0];
    end
  end

  assign idx_o     = idx_q;
  assign sel_o     = sel_q;
  assign wr_en_o   = reg_we_i && (reg_addr_i == REG_DATA);
  assign restart_o = reg_we_i && (reg_addr_i == REG_RESTART);

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_IDX:   reg_rdata_o[IDX_W-1:0]   = idx_q;
      REG_SEL:   reg_rdata_o[SEL_W-1:0]   = sel_q;
      REG_STATE: reg_rdata_o[STATE_W-1:0] = state_i;
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/lut_fsm_table.sv
module lut_fsm_table #(
  parameter int IDX_W   = 3,
  parameter int ENTRY_W = 3,
  parameter int SEL_W   = 1,
  parameter int NSLICE  = 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [IDX_W-1:0]   wr_idx_i,
  input  logic [SEL_W-1:0]   wr_sel_i,
  input  logic [31:0]        wr_data_i,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [ENTRY_W-1:0] rd_entry_o
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int LOW_W = (ENTRY_W < 32) ? ENTRY_W : 32;

  logic [ENTRY_W-1:0] mem_q [DEPTH];

  // only bits of the selected slice are touched; unused word bits are not stored
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      for (int b = 0; b < ENTRY_W; b++)
        if ((b / 32) == int'(wr_sel_i)) mem_q[wr_idx_i][b] <= wr_data_i[b % 32];
    end
  end

  assign rd_entry_o = mem_q[rd_idx_i];

  assert_slice_write_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == '0) |=>
      (mem_q[$past(wr_idx_i)][LOW_W-1:0] == $past(wr_data_i[LOW_W-1:0])));

  assert_oob_select_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && int'(wr_sel_i) >= NSLICE) |=>
      (mem_q[$past(wr_idx_i)] == $past(mem_q[wr_idx_i])));
endmodule

// File: rtl/lut_fsm_core.sv
module lut_fsm_core #(
  parameter int STATE_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  input  logic [STATE_W-1:0] next_i,
  output logic [STATE_W-1:0] state_o
);
  logic [STATE_W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        state_q <= '0;
    else if (restart_i) state_q <= '0;
    else                state_q <= next_i;
  end

  assign state_o = state_q;

  assert_restart_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (state_q == '0));

  assert_next_state_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !restart_i |=> (state_q == $past(next_i)));
endmodule

// File: rtl/lut_fsm.sv
module lut_fsm #(
  parameter int STATE_W  = 2,
  parameter int INPUT_W  = 1,
  parameter int OUTPUT_W = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [INPUT_W-1:0]  in_i,
  output logic [OUTPUT_W-1:0] out_o,
  input  logic                reg_we_i,
  input  logic [2:0]          reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o
);
  localparam int IDX_W   = STATE_W + INPUT_W;
  localparam int ENTRY_W = STATE_W + OUTPUT_W;
  localparam int NSLICE  = (ENTRY_W + 31) / 32;
  localparam int SEL_W   = $clog2(NSLICE) + 1;  // one spare bit so out-of-range selects exist

  logic [STATE_W-1:0] state;
  logic [IDX_W-1:0]   wr_idx;
  logic [SEL_W-1:0]   wr_sel;
  logic               wr_en;
  logic               restart;
  logic [ENTRY_W-1:0] entry;

  lut_fsm_regs #(.IDX_W(IDX_W), .SEL_W(SEL_W), .STATE_W(STATE_W)) u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .state_i(state), .idx_o(wr_idx), .sel_o(wr_sel),
    .wr_en_o(wr_en), .restart_o(restart)
  );

  lut_fsm_table #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W), .SEL_W(SEL_W), .NSLICE(NSLICE)) u_table (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_sel_i(wr_sel),
    .wr_data_i(reg_wdata_i), .rd_idx_i({state, in_i}), .rd_entry_o(entry)
  );

  lut_fsm_core #(.STATE_W(STATE_W)) u_core (
    .clk_i, .rst_ni, .restart_i(restart),
    .next_i(entry[ENTRY_W-1:OUTPUT_W]), .state_o(state)
  );

  assign out_o = entry[OUTPUT_W-1:0];
endmodule

// File: tb/lut_fsm_test.sv
module lut_fsm_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [0:0]  in_v = '0;
  logic [0:0]  out_v;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lut_fsm uut (
    .clk_i(clk), .rst_ni(rst_n), .in_i(in_v), .out_o(out_v),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  // entries {next[1:0], out}, index {state, in}
  localparam logic [2:0] PROG [8] = '{3'b000, 3'b011, 3'b010, 3'b101,
                                      3'b111, 3'b110, 3'b000, 3'b001};
  // vectors {in, state before edge, expected out}
  localparam logic [3:0] VEC [10] = '{
    4'b1_00_1, 4'b0_01_0, 4'b1_01_1, 4'b1_10_0, 4'b1_11_1,
    4'b1_00_1, 4'b1_01_1, 4'b0_10_1, 4'b0_11_0, 4'b0_00_0};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = 3'd4;
  endtask

  task automatic read_state(output logic [31:0] v);
    addr = 3'd4;
    #1 v = rdata;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] st;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    read_state(st); check("R1 state", st, 0);
    check("R1 out in0", out_v, 0);
    in_v = 1'b1; #1 check("R1 out in1", out_v, 0);
    @(negedge clk); read_state(st); check("R1 stays 0", st, 0);
    in_v = 1'b0;

    // program: entry 0 is 0, so state holds at 0 with in=0
    for (int i = 0; i < 8; i++) begin
      reg_write(3'd0, 32'(i));
      reg_write(3'd2, {29'd0, PROG[i]});
    end
    // R7 read back of index and select registers
    addr = 3'd0; #1 check("R7 idx readback", rdata, 7);
    addr = 3'd1; #1 check("R7 sel readback", rdata, 0);
    reg_write(3'd3, 32'hdead);

    // R2 R3 R4 vector walk
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      in_v = VEC[k][3];
      read_state(st);
      check("R2 state", st, {30'd0, VEC[k][2:1]});
      check("R3 R4 out", out_v, {31'd0, VEC[k][0]});
    end
    @(negedge clk); in_v = 1'b0; read_state(st); check("R2 final", st, 0);

    // R6 restart from state 2, table preserved
    in_v = 1'b1; @(negedge clk); @(negedge clk);
    read_state(st); check("R6 reached 2", st, 2);
    in_v = 1'b0; // state 2 in0 -> 3 at next edge, restart wins
    we = 1'b1; addr = 3'd3; wdata = 32'h0;
    @(negedge clk); we = 1'b0;
    read_state(st); check("R6 restart", st, 0);
    in_v = 1'b1; #1 check("R6 table kept", out_v, 1);
    in_v = 1'b0;

    // R9 index/select writes alone change nothing
    reg_write(3'd0, 32'd1);
    reg_write(3'd1, 32'd0);
    read_state(st); check("R9 state", st, 0);
    in_v = 1'b1; #1 check("R9 out", out_v, 1);
    in_v = 1'b0;

    // R5 out-of-range slice select ignored
    reg_write(3'd1, 32'd1);
    reg_write(3'd2, 32'd0);
    in_v = 1'b1; #1 check("R5 out kept", out_v, 1);
    in_v = 1'b0;
    reg_write(3'd1, 32'd0);

    // R8 rewrite entry {0,1} while in use
    @(negedge clk);
    in_v = 1'b1; we = 1'b1; addr = 3'd2; wdata = 32'd0;
    #1 check("R8 out before commit", out_v, 1);
    @(negedge clk); we = 1'b0;
    read_state(st); check("R8 old next used", st, 1);
    reg_write(3'd3, 32'd0);
    in_v = 1'b1; #1 check("R8 new entry out", out_v, 0);
    @(negedge clk); read_state(st); check("R8 new entry next", st, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule